// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Latch Update

This block serves 32 general-purpose pins from a single-port register bus. Every pin has three settings: a direction bit, an output latch, and a 2-bit function selector. The selector either leaves the pin under GPIO control or hands the pad to one of three peripheral lanes. Software can load the output latch as a whole word. It can also change the latch one bit at a time through write-one set, clear and toggle addresses, so no read-modify-write sequence is needed. Reading the data address returns the pad level after a two-flop synchronizer.

Function-select and qualification-select writes do not act at once. They pass through a fixed two-cycle delay line and only then take effect. Qualification filters are not part of this block: it only holds the qualification selection and drives it out, already delayed, to a filter stage outside. The block also drives a pull-up enable per pin, and it raises a wake request when any wake-enabled pin reads high after synchronization.

The block has no state machine. Its sequential structure is made of four parts: a two-stage synchronizer, a two-stage configuration delay line, the active configuration registers it feeds, and the plain registers of the register file.

Top module: `gpio_bank`

## Requirements
- R1: When reset is released, the following all read 0: direction, output latch, both function-select words, qualification select and wake enable. The pull-up enable is 0 on pins 0 to 11 and 1 on pins 12 to 31, which is 0xFFFFF000. While reset is asserted, pad_oe is 0.
- R2: The word address map is: 0 data, 1 set, 2 clear, 3 toggle, 4 direction, 5 function select for pins 0-15, 6 function select for pins 16-31, 7 qualification select, 8 pull-up enable, 9 wake enable. A write to address 0 loads the whole output latch. A read of address 1, 2 or 3 returns the output latch.
- R3: A write to address 1 sets every latch bit that is written as 1. Latch bits written as 0 keep their value.
- R4: A write to address 2 clears every latch bit that is written as 1. Latch bits written as 0 keep their value.
- R5: A write to address 3 inverts every latch bit that is written as 1. Latch bits written as 0 keep their value.
- R6: The latch can be loaded while a pin is an input, and pad_oe stays 0 meanwhile. In the cycle after the direction bit is written to 1, the pad drives the value that was loaded before.
- R7: A pin with function code 0 is a GPIO pin: pad_out is its latch bit and pad_oe is its direction bit.
- R8: Function codes 1, 2 and 3 select peripheral lanes 0, 1 and 2. Pin i then takes pad_out and pad_oe from bits [lane*32+i] of alt_out and alt_oe. Pin i's code sits at bits [2i+1:2i] of word 5 for i<16, and at bits [2(i-16)+1:2(i-16)] of word 6 for i>=16.
- R9: A write to address 5, 6 or 7 that is sampled at clock edge k takes effect at edge k+2. This holds for the readback, for the pad muxing and for the qual_sel output. Nothing changes at edges k and k+1.
- R10: A read of address 0 returns pad_in as it was sampled two clock edges earlier.
- R11: qual_sel carries the active qualification-select word.
- R12: pull_en carries the pull-up enable register, and a write to address 8 updates it.
- R13: wake_req is 1 exactly when some pin has its wake-enable bit set and its synchronized level is 1.
- R14: Writes to addresses 10 to 15 change no state, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, a combinational function of bus_addr |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 96 | Peripheral lane outputs, lane-major |
| alt_oe | input | 96 | Peripheral lane output enables, lane-major |
| pull_en | output | 32 | Per-pin pull-up enables |
| qual_sel | output | 32 | Active qualification selection for the external filter |
| wake_req | output | 1 | Low-power wake request |

## Verification
A corrupted latch bit shows up as the wrong value on the set-address readback right after the next bus write. When its pin is a GPIO output, the same fault also shows on pad_out in that cycle. If the delay line is one stage short or one stage long, the function-select readback and the pad muxing change one cycle early or one cycle late. Checks that look at the edge after the write and at each of the two edges after it catch this. A synchronizer stage that is missing or extra moves the data readback and wake_req by one cycle after a pad change.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPIN          = 32;
    localparam int DW            = 32;
    localparam int ADDR_W        = 4;
    localparam int NALT          = 3;
    localparam int FSEL_W        = $clog2(NALT + 1);
    localparam int FSEL_BITS     = NPIN * FSEL_W;
    localparam int CFG_DELAY     = 2;
    localparam int SYNC_STAGES   = 2;
    localparam int PULL_OFF_PINS = 12;

    typedef enum logic [ADDR_W-1:0] {
        A_DATA   = 4'd0,
        A_SET    = 4'd1,
        A_CLR    = 4'd2,
        A_TGL    = 4'd3,
        A_DIR    = 4'd4,
        A_FSELLO = 4'd5,
        A_FSELHI = 4'd6,
        A_QSEL   = 4'd7,
        A_PULL   = 4'd8,
        A_WAKE   = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        CFG_NONE,
        CFG_FLO,
        CFG_FHI,
        CFG_QSEL
    } cfg_tgt_e;

    typedef struct packed {
        cfg_tgt_e        tgt;
        logic [DW-1:0]   data;
    } cfg_req_t;

    function automatic logic [NPIN-1:0] pull_reset_value();
        logic [NPIN-1:0] v;
        for (int i = 0; i < NPIN; i++) begin
            v[i] = (i >= PULL_OFF_PINS);
        end
        return v;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg[s] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_cfg_delay.sv
module gpio_cfg_delay
    import gpio_pkg::*;
#(
    parameter int DEPTH = CFG_DELAY
) (
    input  logic          clk,
    input  logic          rst_n,
    input  cfg_req_t      req_in,
    output logic [DW-1:0] fsel_lo,
    output logic [DW-1:0] fsel_hi,
    output logic [DW-1:0] qsel
);
    cfg_req_t pipe [DEPTH];

    // Delay line: one register per cycle of delay.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) begin
                pipe[d] <= '{tgt: CFG_NONE, data: '0};
            end
        end else begin
            pipe[0] <= req_in;
            for (int d = 1; d < DEPTH; d++) begin
                pipe[d] <= pipe[d-1];
            end
        end
    end

    // Active configuration, loaded from the last stage of the line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsel_lo <= '0;
            fsel_hi <= '0;
            qsel    <= '0;
        end else begin
            unique case (pipe[DEPTH-1].tgt)
                CFG_FLO:  fsel_lo <= pipe[DEPTH-1].data;
                CFG_FHI:  fsel_hi <= pipe[DEPTH-1].data;
                CFG_QSEL: qsel    <= pipe[DEPTH-1].data;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int N  = NPIN,
    parameter int NA = NALT,
    parameter int FW = FSEL_W
) (
    input  logic [N*FW-1:0] fsel,
    input  logic [N-1:0]    dir,
    input  logic [N-1:0]    latch,
    input  logic [NA*N-1:0] alt_out,
    input  logic [NA*N-1:0] alt_oe,
    output logic [N-1:0]    pad_out,
    output logic [N-1:0]    pad_oe
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic [FW-1:0] code;
        assign code = fsel[i*FW +: FW];

        always_comb begin
            pad_out[i] = latch[i];
            pad_oe[i]  = dir[i];
            for (int l = 0; l < NA; l++) begin
                if (int'(code) == l + 1) begin
                    pad_out[i] = alt_out[l*N + i];
                    pad_oe[i]  = alt_oe[l*N + i];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NPIN-1:0]      pad_in,
    output logic [NPIN-1:0]      pad_out,
    output logic [NPIN-1:0]      pad_oe,
    input  logic [NALT*NPIN-1:0] alt_out,
    input  logic [NALT*NPIN-1:0] alt_oe,
    output logic [NPIN-1:0]      pull_en,
    output logic [DW-1:0]        qual_sel,
    output logic                 wake_req
);
    localparam logic [NPIN-1:0] PULL_RST = pull_reset_value();

    logic [NPIN-1:0]      latch_q;
    logic [NPIN-1:0]      dir_q;
    logic [NPIN-1:0]      pull_q;
    logic [NPIN-1:0]      wake_q;
    logic [NPIN-1:0]      pin_sync;
    logic [DW-1:0]        fsel_lo;
    logic [DW-1:0]        fsel_hi;
    logic [FSEL_BITS-1:0] fsel_act;
    cfg_req_t             cfg_req;

    // Register file writes: latch and its aliases, direction, pull-ups, wake.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= PULL_RST;
            wake_q  <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DATA:  latch_q <= bus_wdata[NPIN-1:0];
                A_SET:   latch_q <= latch_q | bus_wdata[NPIN-1:0];
                A_CLR:   latch_q <= latch_q & ~bus_wdata[NPIN-1:0];
                A_TGL:   latch_q <= latch_q ^ bus_wdata[NPIN-1:0];
                A_DIR:   dir_q   <= bus_wdata[NPIN-1:0];
                A_PULL:  pull_q  <= bus_wdata[NPIN-1:0];
                A_WAKE:  wake_q  <= bus_wdata[NPIN-1:0];
                default: ;
            endcase
        end
    end

    // Configuration writes enter the delay line instead of a register.
    always_comb begin
        cfg_req = '{tgt: CFG_NONE, data: bus_wdata};
        if (bus_wr) begin
            case (bus_addr)
                A_FSELLO: cfg_req.tgt = CFG_FLO;
                A_FSELHI: cfg_req.tgt = CFG_FHI;
                A_QSEL:   cfg_req.tgt = CFG_QSEL;
                default:  cfg_req.tgt = CFG_NONE;
            endcase
        end
    end

    gpio_cfg_delay #(.DEPTH(CFG_DELAY)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (cfg_req),
        .fsel_lo (fsel_lo),
        .fsel_hi (fsel_hi),
        .qsel    (qual_sel)
    );

    assign fsel_act = {fsel_hi, fsel_lo};

    gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    gpio_pad_mux #(.N(NPIN), .NA(NALT), .FW(FSEL_W)) u_mux (
        .fsel    (fsel_act),
        .dir     (dir_q),
        .latch   (latch_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    // Read mux.
    always_comb begin
        case (bus_addr)
            A_DATA:                bus_rdata = pin_sync;
            A_SET, A_CLR, A_TGL:   bus_rdata = latch_q;
            A_DIR:                 bus_rdata = dir_q;
            A_FSELLO:              bus_rdata = fsel_lo;
            A_FSELHI:              bus_rdata = fsel_hi;
            A_QSEL:                bus_rdata = qual_sel;
            A_PULL:                bus_rdata = pull_q;
            A_WAKE:                bus_rdata = wake_q;
            default:               bus_rdata = '0;
        endcase
    end

    assign pull_en  = pull_q;
    assign wake_req = |(wake_q & pin_sync);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DW-1:0]        bus_wdata,
    input logic [DW-1:0]        bus_rdata,
    input logic [NPIN-1:0]      pad_in,
    input logic [NPIN-1:0]      pad_oe,
    input logic [NPIN-1:0]      latch,
    input logic [FSEL_BITS-1:0] fsel_act
);
    logic [2:0] since_rst;
    logic       fsel_wr;
    logic       flo_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    assign flo_wr  = bus_wr && (bus_addr == A_FSELLO);
    assign fsel_wr = flo_wr || (bus_wr && (bus_addr == A_FSELHI));

    // R1
    reset_oe_chk: assert property (@(posedge clk) !rst_n |-> pad_oe == '0);

    // R3
    set_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $past(bus_wr) && $past(bus_addr) == A_SET)
        |-> latch == ($past(latch) | $past(bus_wdata)));

    // R4
    clr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $past(bus_wr) && $past(bus_addr) == A_CLR)
        |-> latch == ($past(latch) & ~$past(bus_wdata)));

    // R5
    tgl_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && $past(bus_wr) && $past(bus_addr) == A_TGL)
        |-> latch == ($past(latch) ^ $past(bus_wdata)));

    // R9
    fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && !$past(fsel_wr, 3)) |-> $stable(fsel_act));

    // R9
    fsel_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && $past(flo_wr, 3))
        |-> fsel_act[DW-1:0] == $past(bus_wdata, 3));

    // R10
    data_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && bus_addr == A_DATA)
        |-> bus_rdata == $past(pad_in, 2));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .latch     (latch_q),
    .fsel_act  (fsel_act)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'd0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [95:0] alt_out = 96'd0;
    logic [95:0] alt_oe = 96'd0;
    logic [31:0] pull_en;
    logic [31:0] qual_sel;
    logic        wake_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_bank u_gpio_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .pull_en(pull_en), .qual_sel(qual_sel), .wake_req(wake_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 pad_oe in reset", pad_oe, 32'h0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        rd(4'd4, v); check("R1 dir", v, 32'h0);
        rd(4'd1, v); check("R1 latch", v, 32'h0);
        rd(4'd5, v); check("R1 fsel lo", v, 32'h0);
        rd(4'd6, v); check("R1 fsel hi", v, 32'h0);
        rd(4'd7, v); check("R1 qsel", v, 32'h0);
        rd(4'd9, v); check("R1 wake", v, 32'h0);
        check("R1 pull_en", pull_en, 32'hFFFF_F000);
        check("R1 pad_oe", pad_oe, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] v;
        wr(4'd0, 32'hA5A5_0F0F); rd(4'd1, v); check("R2 data write", v, 32'hA5A5_0F0F);
        wr(4'd1, 32'h0000_00F0); rd(4'd2, v); check("R3 set", v, 32'hA5A5_0FFF);
        wr(4'd2, 32'hA000_000F); rd(4'd3, v); check("R4 clear", v, 32'h05A5_0FF0);
        wr(4'd3, 32'hFFFF_0000); rd(4'd1, v); check("R5 toggle", v, 32'hFA5A_0FF0);
    endtask

    task automatic t_preload();
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h0000_0001);
        check("R6 oe low while input", pad_oe, 32'h0);
        wr(4'd4, 32'h0000_0001);
        check("R6 oe after dir", pad_oe, 32'h0000_0001);
        check("R7 pad_out is latch", pad_out, 32'h0000_0001);
    endtask

    task automatic t_func();
        logic [31:0] v;
        alt_out = {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000};
        alt_oe  = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
        wr(4'd5, 32'h0000_0039);
        rd(4'd5, v); check("R9 fsel edge k", v, 32'h0);
        check("R9 pin0 oe edge k", {31'd0, pad_oe[0]}, 32'd1);
        @(negedge clk);
        rd(4'd5, v); check("R9 fsel edge k+1", v, 32'h0);
        check("R9 pin0 oe edge k+1", {31'd0, pad_oe[0]}, 32'd1);
        @(negedge clk);
        rd(4'd5, v); check("R9 fsel edge k+2", v, 32'h0000_0039);
        check("R8 lane pads out", pad_out[2:0], 32'h2);
        check("R8 lane pads oe", pad_oe[2:0], 32'h6);
        wr(4'd6, 32'h0000_0002);
        @(negedge clk);
        check("R9 hi not yet", {31'd0, pad_oe[16]}, 32'd0);
        @(negedge clk);
        check("R8 pin16 lane1 oe", {31'd0, pad_oe[16]}, 32'd1);
        check("R8 pin16 lane1 out", {31'd0, pad_out[16]}, 32'd1);
        wr(4'd7, 32'h0000_FF00);
        check("R11 qual edge k", qual_sel, 32'h0);
        @(negedge clk);
        check("R11 qual edge k+1", qual_sel, 32'h0);
        @(negedge clk);
        check("R11 qual edge k+2", qual_sel, 32'h0000_FF00);
    endtask

    task automatic t_sync();
        logic [31:0] v;
        rd(4'd0, v); check("R10 data before", v, 32'h0);
        pad_in = 32'hDEAD_BEEF;
        @(negedge clk); rd(4'd0, v); check("R10 one edge", v, 32'h0);
        @(negedge clk); rd(4'd0, v); check("R10 two edges", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_wake_pull();
        wr(4'd9, 32'h0000_0010);
        check("R13 wake low pin", {31'd0, wake_req}, 32'd0);
        wr(4'd9, 32'h0000_0020);
        check("R13 wake high pin", {31'd0, wake_req}, 32'd1);
        wr(4'd8, 32'h0000_1234);
        check("R12 pull write", pull_en, 32'h0000_1234);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(4'd15, 32'hFFFF_FFFF);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd15, v); check("R14 read zero", v, 32'h0);
        rd(4'd1, v);  check("R14 latch kept", v, 32'h0000_0001);
        rd(4'd4, v);  check("R14 dir kept", v, 32'h0000_0001);
        check("R14 pull kept", pull_en, 32'h0000_1234);
    endtask

    initial begin
        t_reset();
        t_latch();
        t_preload();
        t_func();
        t_sync();
        t_wake_pull();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule